// File: doc/BRIEF.md
# Switchable Convolutional Encoder with Rate-3/4 Puncturing

This block takes a scrambled bit stream through a valid/ready handshake and turns each frame into coded bits for the bit interleaver that follows it. It is a rate-1/2 convolutional encoder, and two codes are built in. The long code has constraint length 6, with octal generators 65 and 57. The short code has constraint length 4, with octal generators 15 and 17. All four generators are parameters. Either code can be thinned to rate 3/4 by a fixed deletion pattern. Coded bits leave one per cycle, with a flag on the final bit of the frame.

The two configuration inputs select the code and the rate. They are sampled when the first bit of a frame is accepted, and they are held until the frame ends. Each frame starts from a zeroed history register. The frame's final data bit is marked with `in_last`. After it, the block appends K-1 zero tail bits by itself, so the history returns to the all-zero state. The tail bits are coded and punctured exactly like data bits.

The controller has five states:

- `ST_IDLE`: between frames. The block is ready, and history and phase are treated as zero.
- `ST_TAKE`: inside a frame, waiting for the next data bit.
- `ST_SEND_A`: first generator output on the port.
- `ST_SEND_B`: second generator output on the port.
- `ST_FLUSH`: codes one internal zero tail bit.

The transitions are:

- Accept: `ST_IDLE` or `ST_TAKE` to a send state.
- Flush-code: `ST_FLUSH` to a send state.
- Pair: `ST_SEND_A` to `ST_SEND_B`.
- Continue: from the last send state of a bit to `ST_TAKE`.
- Drain: from the last send state of a bit to `ST_FLUSH`.
- Close: from the last send state of the final tail bit to `ST_IDLE`.

Top module: `dual_conv_encoder`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: With `cfg_short_k`=0 and `cfg_rate34`=0, each input bit x gives A = parity of 65(octal) applied to the window {x, previous 5 bits}. The generator MSB taps x. B is formed the same way with 57(octal). A is emitted first, in the cycle after the accepting edge, and B follows in the next cycle.
- R3: With `cfg_short_k`=1 and `cfg_rate34`=0, the same rule applies with generators 15 and 17 (octal) over {x, previous 3 bits}.
- R4: With `cfg_rate34`=1, coded steps are numbered from 0 within the frame, counting data and tail bits. Step t mod 3 = 0 emits A then B, step 1 emits only B, and step 2 emits only A.
- R5: After the data bit marked `in_last`, K-1 zero tail bits are coded: 5 for the long code and 3 for the short code. The frame then ends, and the history bits used by the active code are all zero.
- R6: `out_last` is 1 exactly on the final coded bit of the frame. In the next cycle `in_ready` is 1.
- R7: The configuration inputs are captured when the first bit of a frame is accepted. Changing them during the frame has no effect on that frame.
- R8: Every frame starts from zero history, whatever the previous frame left behind.
- R9: `in_ready` is 0 whenever `out_valid` is 1. Each accepted bit gives its coded bits on consecutive cycles.
- R10: While `in_valid` is 0 inside a frame, the block waits in `ST_TAKE` and emits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_short_k | input | 1 | 1 selects the constraint-length-4 code |
| cfg_rate34 | input | 1 | 1 selects punctured rate 3/4 |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Block accepts a bit this cycle |
| in_bit | input | 1 | Scrambled data bit |
| in_last | input | 1 | Marks the final data bit of a frame |
| out_valid | output | 1 | Coded bit present |
| out_bit | output | 1 | Coded bit |
| out_last | output | 1 | Final coded bit of the frame |

## Verification
A bit accepted at a rising edge shows its first kept coded bit in the cycle that follows. A kept second bit comes one cycle after that. `in_ready` rises again in the cycle after the bit's last send cycle. Each tail bit costs one silent flush cycle and then its one or two send cycles. The bench drives inputs and samples every output on the falling edge. It compares each `out_valid` cycle against the next entry of a queue that it builds arithmetically, so no check depends on guessing a cycle number. The frame length and the final `in_ready` are then checked once the `out_last` cycle has passed.

// File: rtl/cenc_pkg.sv
package cenc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE,
        ST_SEND_A,
        ST_SEND_B,
        ST_FLUSH
    } enc_state_e;

    typedef struct packed {
        logic keep_a;
        logic keep_b;
    } keep_t;

    localparam int unsigned PUNCT_PERIOD = 3;

endpackage

// File: rtl/cenc_parity.sv
module cenc_parity #(
    parameter int unsigned      K  = 6,
    parameter logic [K-1:0]     GA = '1,
    parameter logic [K-1:0]     GB = '1
) (
    input  logic [K-1:0] win,
    output logic         bit_a,
    output logic         bit_b
);

    always_comb begin
        bit_a = ^(win & GA);
        bit_b = ^(win & GB);
    end

endmodule

// File: rtl/cenc_punct.sv
module cenc_punct
    import cenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  step,
    input  logic  rate34,
    output keep_t keep
);

    localparam int unsigned PW = $clog2(PUNCT_PERIOD);
    localparam logic [PW-1:0] LAST_PH = PW'(PUNCT_PERIOD - 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] cur_ph;

    always_comb begin
        cur_ph = restart ? '0 : phase_q;
        if (!rate34) begin
            keep = '{keep_a: 1'b1, keep_b: 1'b1};
        end else begin
            unique case (cur_ph)
                PW'(0):  keep = '{keep_a: 1'b1, keep_b: 1'b1};
                PW'(1):  keep = '{keep_a: 1'b0, keep_b: 1'b1};
                default: keep = '{keep_a: 1'b1, keep_b: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= (cur_ph == LAST_PH) ? '0 : cur_ph + PW'(1);
        end else if (restart) begin
            phase_q <= '0;
        end
    end

endmodule

// File: rtl/dual_conv_encoder.sv
module dual_conv_encoder
    import cenc_pkg::*;
#(
    parameter int unsigned          K_LONG  = 6,
    parameter int unsigned          K_SHORT = 4,
    parameter logic [K_LONG-1:0]    G_LA    = 6'o65,
    parameter logic [K_LONG-1:0]    G_LB    = 6'o57,
    parameter logic [K_SHORT-1:0]   G_SA    = 4'o15,
    parameter logic [K_SHORT-1:0]   G_SB    = 4'o17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_short_k,
    input  logic cfg_rate34,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_last,
    output logic out_valid,
    output logic out_bit,
    output logic out_last
);

    localparam int unsigned MEM = K_LONG - 1;
    localparam int unsigned SMEM = K_SHORT - 1;
    localparam int unsigned TW  = $clog2(K_LONG);
    localparam logic [TW-1:0] TAIL_LONG  = TW'(K_LONG - 1);
    localparam logic [TW-1:0] TAIL_SHORT = TW'(K_SHORT - 1);

    enc_state_e state_q, state_d;

    logic           k4_q, r34_q;
    logic [MEM-1:0] sr_q;
    logic           a_q, b_q, kb_q, fin_q;
    logic [TW-1:0]  tail_q;

    logic           frame_open, in_fire, enc_fire, enc_bit;
    logic           k4_use, r34_use;
    logic [MEM-1:0] hist;
    logic [K_LONG-1:0]  win_long;
    logic [K_SHORT-1:0] win_short;
    logic           la, lb, sa, sb, code_a, code_b;
    keep_t          keep;
    logic [TW-1:0]  tail_load;
    enc_state_e     first_send, after_send;

    // Shared datapath: history and configuration selection
    always_comb begin
        frame_open = (state_q == ST_IDLE);
        in_fire    = in_valid && in_ready;
        enc_fire   = in_fire || (state_q == ST_FLUSH);
        enc_bit    = in_fire ? in_bit : 1'b0;
        k4_use     = frame_open ? cfg_short_k : k4_q;
        r34_use    = frame_open ? cfg_rate34  : r34_q;
        hist       = frame_open ? '0 : sr_q;
        win_long   = {enc_bit, hist};
        win_short  = {enc_bit, hist[MEM-1 -: SMEM]};
        tail_load  = k4_use ? TAIL_SHORT : TAIL_LONG;
    end

    cenc_parity #(.K(K_LONG), .GA(G_LA), .GB(G_LB)) par_long_i (
        .win   (win_long),
        .bit_a (la),
        .bit_b (lb)
    );

    cenc_parity #(.K(K_SHORT), .GA(G_SA), .GB(G_SB)) par_short_i (
        .win   (win_short),
        .bit_a (sa),
        .bit_b (sb)
    );

    always_comb begin
        code_a = k4_use ? sa : la;
        code_b = k4_use ? sb : lb;
    end

    cenc_punct punct_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_open),
        .step    (enc_fire),
        .rate34  (r34_use),
        .keep    (keep)
    );

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k4_q   <= 1'b0;
            r34_q  <= 1'b0;
            sr_q   <= '0;
            a_q    <= 1'b0;
            b_q    <= 1'b0;
            kb_q   <= 1'b0;
            fin_q  <= 1'b0;
            tail_q <= '0;
        end else begin
            if (frame_open && in_fire) begin
                k4_q  <= cfg_short_k;
                r34_q <= cfg_rate34;
            end
            if (enc_fire) begin
                sr_q  <= {enc_bit, hist[MEM-1:1]};
                a_q   <= code_a;
                b_q   <= code_b;
                kb_q  <= keep.keep_b;
                fin_q <= (state_q == ST_FLUSH) && (tail_q == TW'(1));
            end
            if (in_fire && in_last) begin
                tail_q <= tail_load;
            end else if (state_q == ST_FLUSH) begin
                tail_q <= tail_q - TW'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        first_send = keep.keep_a ? ST_SEND_A : ST_SEND_B;
        if (fin_q) begin
            after_send = ST_IDLE;
        end else if (tail_q != '0) begin
            after_send = ST_FLUSH;
        end else begin
            after_send = ST_TAKE;
        end
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_fire) state_d = first_send;
            ST_TAKE:   if (in_fire) state_d = first_send;
            ST_FLUSH:  state_d = first_send;
            ST_SEND_A: state_d = kb_q ? ST_SEND_B : after_send;
            ST_SEND_B: state_d = after_send;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TAKE: in_ready = 1'b1;
            ST_SEND_A: begin
                out_valid = 1'b1;
                out_bit   = a_q;
                out_last  = fin_q && !kb_q;
            end
            ST_SEND_B: begin
                out_valid = 1'b1;
                out_bit   = b_q;
                out_last  = fin_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cenc_checker.sv
module cenc_checker #(
    parameter int unsigned MEM  = 5,
    parameter int unsigned SMEM = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_last,
    input logic           k4_q,
    input logic           r34_q,
    input logic [MEM-1:0] sr_q
);

    // R2 / R9: an accepted bit is followed at once by coded output and no readiness
    p_accept_then_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R6: the final flag only rides on a valid coded bit
    p_last_is_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: after the final coded bit the block is ready for a new frame
    p_last_then_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (in_ready && !out_valid));

    // R5: the tail leaves the active code's history at zero
    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (k4_q ? (sr_q[MEM-1 -: SMEM] == '0) : (sr_q == '0)));

    // R7: the captured configuration stays put while a frame is emitting
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> ($stable(k4_q) && $stable(r34_q)));

endmodule

bind dual_conv_encoder cenc_checker #(.MEM(MEM), .SMEM(SMEM)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .k4_q      (k4_q),
    .r34_q     (r34_q),
    .sr_q      (sr_q)
);

// File: tb/dual_conv_encoder_tb.sv
module dual_conv_encoder_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_short_k, cfg_rate34, in_valid, in_bit, in_last;
    logic in_ready, out_valid, out_bit, out_last;

    dual_conv_encoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_short_k (cfg_short_k),
        .cfg_rate34  (cfg_rate34),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_bit      (in_bit),
        .in_last     (in_last),
        .out_valid   (out_valid),
        .out_bit     (out_bit),
        .out_last    (out_last)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    din [0:31];
    bit    exp_bits [0:63];
    int    exp_n = 0;
    int    got_n = 0;
    bit    mon_on = 1'b0;
    string tag = "R2";

    task automatic note(input bit ok, input string req, input string what,
                        input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference coding from the requirement text (R2..R5)
    task automatic build(input int n, input bit k4, input bit r34);
        int          kk = k4 ? 4 : 6;
        logic [5:0]  ga = k4 ? 6'o15 : 6'o65;
        logic [5:0]  gb = k4 ? 6'o17 : 6'o57;
        logic [4:0]  past = '0;
        exp_n = 0;
        for (int t = 0; t < n + kk - 1; t++) begin
            bit x = (t < n) ? din[t] : 1'b0;
            bit a = ga[kk-1] & x;
            bit b = gb[kk-1] & x;
            for (int j = 1; j < kk; j++) begin
                a ^= ga[kk-1-j] & past[j-1];
                b ^= gb[kk-1-j] & past[j-1];
            end
            past = {past[3:0], x};
            if (!r34 || (t % 3) != 1) begin exp_bits[exp_n] = a; exp_n++; end
            if (!r34 || (t % 3) != 2) begin exp_bits[exp_n] = b; exp_n++; end
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid && in_ready)
                note(1'b0, "R9", "ready_during_output", 1, 0);
            if (out_valid) begin
                if (got_n >= exp_n) begin
                    note(1'b0, "R5", "extra_coded_bit", got_n, exp_n);
                end else begin
                    note(out_bit == exp_bits[got_n], tag, "coded_bit",
                         int'(out_bit), int'(exp_bits[got_n]));
                    note(out_last == (got_n == exp_n - 1), "R6", "last_flag",
                         int'(out_last), int'(got_n == exp_n - 1));
                end
                got_n++;
            end
        end
    end

    task automatic run_frame(input int n, input bit k4, input bit r34,
                             input bit flip, input bit gaps, input string t_over);
        int guard;
        build(n, k4, r34);
        got_n = 0;
        if (t_over != "") tag = t_over;
        else tag = r34 ? "R4" : (k4 ? "R3" : "R2");
        cfg_short_k = k4;
        cfg_rate34  = r34;
        for (int i = 0; i < n; i++) begin
            guard = 0;
            while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
            if (gaps && i > 0) begin
                // R10: idle input inside the frame produces nothing
                @(negedge clk);
                note(!out_valid && in_ready, "R10", "idle_gap", int'(out_valid), 0);
            end
            in_valid = 1'b1;
            in_bit   = din[i];
            in_last  = (i == n - 1);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (flip && i == 0) begin
                cfg_short_k = ~k4;
                cfg_rate34  = ~r34;
            end
        end
        guard = 0;
        while (!(got_n >= exp_n && in_ready) && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        note(got_n == exp_n, "R5", "frame_length", got_n, exp_n);
        note(in_ready == 1'b1, "R6", "ready_after_frame", int'(in_ready), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        rst_n = 1'b0; cfg_short_k = 1'b0; cfg_rate34 = 1'b0;
        in_valid = 1'b0; in_bit = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        note(!out_valid, "R1", "out_valid_reset", int'(out_valid), 0);
        note(!out_last,  "R1", "out_last_reset",  int'(out_last), 0);
        note(in_ready,   "R1", "in_ready_reset",  int'(in_ready), 1);
        mon_on = 1'b1;

        // Exhaustive patterns up to 6 bits over all four configurations
        for (int n = 1; n <= 6; n++)
            for (int p = 0; p < (1 << n); p++)
                for (int c = 0; c < 4; c++) begin
                    for (int i = 0; i < n; i++) din[i] = p[i];
                    run_frame(n, c[0], c[1], 1'b0, 1'b0, "");
                end

        // Longer pseudo-random frames; R7 with mid-frame configuration flips, R10 gaps
        for (int n = 7; n <= 20; n++)
            for (int c = 0; c < 4; c++) begin
                for (int i = 0; i < n; i++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    din[i] = lfsr[0];
                end
                run_frame(n, c[0], c[1], 1'b1, n[0], "R7");
            end

        // R8: a short-code frame of ones, then a long-code single zero bit codes to all zeros
        for (int i = 0; i < 8; i++) din[i] = 1'b1;
        run_frame(8, 1'b1, 1'b0, 1'b0, 1'b0, "");
        din[0] = 1'b0;
        run_frame(1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        run_frame(1, 1'b0, 1'b1, 1'b0, 1'b0, "R8");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule